// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus interface state machine of a processor whose address and data share one set of pins, with the processor as the only bus master. The core hands it one transfer at a time: an address, write data, a read/write flag, a memory/IO flag and a pair of byte-lane enables. The block then runs a bus cycle of at least four clocks (T1, T2, T3, T4). It drives the address with a latch strobe in T1, turns the shared lines around or drives write data from T2, and stretches the cycle with wait states while the addressed device holds READY low. On a read, the data sampled at the end of the data phase is returned to the core during T4.

Another master can take the bus through a hold request. The grant is only given at a cycle boundary, which is either an idle slot or the last clock of a cycle. While the grant is active, every bus output is released to high impedance. A new core request is accepted only in an idle slot or in T4, so cycles can run back to back with no idle clock between them.

Top module: `mux_bus_seq`

## Requirements
- R1: While rst_n is low the sequencer is idle. In the idle state ale=0, rd_n=1, wr_n=1, den_n=1, dt_r=1, m_io=1, bhe_n=1, ad_oe=0, ctl_oe=1 and hlda=0.
- R2: req_ack is high exactly when req_valid=1, hold=0 and the sequencer is idle or in T4. After an acknowledged request, the next clocks are T1, T2 and T3, and the cycle ends with T4.
- R3: In T1, ale=1 and ad_oe=1, ad_out carries the address, and rd_n, wr_n and den_n are inactive (high).
- R4: On a read, ad_oe=0 from T2 through T4, and dt_r=0 from T1 through T4. rd_n is low in T2, T3 and every wait state, and high in T4. ad_in is sampled at the edge that leaves T3 or the last wait state, and it appears on rd_data with rd_valid=1 during T4. rd_n and wr_n are never low together.
- R5: On a write, dt_r=1 and ad_oe=1 from T1 through T4, and ad_out carries the write data (zero-extended) from T2 through T4. wr_n is low in T2, T3 and every wait state, and high in T4.
- R6: den_n is low from T2 through T4, including wait states, and high otherwise.
- R7: From T1 through T4, m_io equals the request's memory flag (1 = memory, 0 = I/O).
- R8: During the cycle, bhe_n = ~be[1], and bit 0 of ad_out in T1 is ~be[0]. The request address bit 0 is ignored. So be=11 gives the pair bhe_n/A0 = 00 (word), be=10 gives 01 (upper byte, odd address), be=01 gives 10 (lower byte, even address), and be=00 gives 11 (no lanes).
- R9: READY is sampled at the edge that ends T3 or a wait state. If it is low, a wait state TW follows, and this repeats. If it is high, T4 follows.
- R10: Every output during a wait state equals its value in the preceding T3.
- R11: hold is honoured only in an idle slot or in T4, and it takes priority over a request in the same slot. hlda rises on the following clock.
- R12: While hlda=1, ad_oe=0 and ctl_oe=0. hlda falls on the clock after hold is sampled low, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core transfer request |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_be | input | 2 | Byte-lane enables, bit 1 upper lane, bit 0 lower lane |
| req_ack | output | 1 | Request accepted this clock |
| rd_data | output | DW | Read data returned to the core |
| rd_valid | output | 1 | rd_data valid (T4 of a read) |
| ready | input | 1 | Device ready, low to insert wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| ad_out | output | AW | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | DW | Data lines in |
| ctl_oe | output | 1 | Output enable for the control strobes |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| bhe_n | output | 1 | Upper byte lane enable, active low |

## Verification
The bench builds the block with its defaults, AW=20 and DW=16. This keeps four address-only bits above the data lanes, so the zero-extension of write data and the placement of the address in T1 can both be told apart on ad_out. A 16-bit lane pair gives room for all four byte-enable combinations, and for odd addresses that must have their bit 0 overridden. Random wait counts from zero to three, and random chaining of requests at T4, reach both the single-wait and repeated-wait paths and the back-to-back path.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;
endpackage

// File: rtl/mbs_seq.sv
module mbs_seq
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    ready,
  input  logic    hold,
  output bus_st_e st,
  output logic    req_ack,
  output logic    hlda
);
  bus_st_e st_nx;
  logic    boundary;

  assign boundary = (st == ST_IDLE) || (st == ST_T4);
  assign req_ack  = req_valid && !hold && boundary;
  assign hlda     = (st == ST_HOLD);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (hold) st_nx = ST_HOLD;
               else if (req_valid) st_nx = ST_T1;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_T3,
      ST_TW:   st_nx = ready ? ST_T4 : ST_TW;
      ST_T4:   if (hold) st_nx = ST_HOLD;
               else if (req_valid) st_nx = ST_T1;
               else st_nx = ST_IDLE;
      ST_HOLD: st_nx = hold ? ST_HOLD : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_T1 |=> st == ST_T2);
  p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_T2 |=> st == ST_T3);
  p_wait_insert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T3 || st == ST_TW) && !ready) |=> st == ST_TW);
  p_wait_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T3 || st == ST_TW) && ready) |=> st == ST_T4);
  p_hold_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> ($past(st) == ST_IDLE || $past(st) == ST_T4));
  p_hold_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);
endmodule

// File: rtl/mbs_req.sv
module mbs_req
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st,
  input  logic          req_ack,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wr,
  input  logic          req_mem,
  input  logic [1:0]    req_be,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wr_q,
  output logic          mem_q,
  output logic [1:0]    be_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic rd_cap_en;

  assign rd_cap_en = (st == ST_T3 || st == ST_TW) && ready && !wr_q;
  assign rd_valid  = (st == ST_T4) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      mem_q   <= 1'b1;
      be_q    <= '0;
    end else if (req_ack) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_wr;
      mem_q   <= req_mem;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_cap_en) rd_data <= ad_in;
  end
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          wr_q,
  input  logic          mem_q,
  input  logic [1:0]    be_q,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ctl_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          m_io,
  output logic          bhe_n
);
  localparam int PADW = AW - DW;

  logic in_cyc, data_ph, strobe_ph;

  assign in_cyc    = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
                     (st == ST_TW) || (st == ST_T4);
  assign data_ph   = (st == ST_T2) || (st == ST_T3) || (st == ST_TW) || (st == ST_T4);
  assign strobe_ph = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);

  always_comb begin
    ale    = (st == ST_T1);
    rd_n   = !(strobe_ph && !wr_q);
    wr_n   = !(strobe_ph && wr_q);
    den_n  = !data_ph;
    dt_r   = in_cyc ? wr_q : 1'b1;
    m_io   = in_cyc ? mem_q : 1'b1;
    bhe_n  = in_cyc ? ~be_q[1] : 1'b1;
    ad_oe  = (st == ST_T1) || (data_ph && wr_q);
    ctl_oe = (st != ST_HOLD);
    if (st == ST_T1)           ad_out = {addr_q[AW-1:1], ~be_q[0]};
    else if (data_ph && wr_q)  ad_out = {{PADW{1'b0}}, wdata_q};
    else                       ad_out = '0;
  end

  p_no_rdwr_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_wait_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_TW |-> $stable({ad_out, ad_oe, ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n}));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wr,
  input  logic          req_mem,
  input  logic [1:0]    req_be,
  output logic          req_ack,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ctl_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          m_io,
  output logic          bhe_n
);
  bus_st_e       st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q, mem_q;
  logic [1:0]    be_q;

  mbs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
    .hold(hold), .st(st), .req_ack(req_ack), .hlda(hlda)
  );

  mbs_req #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .st(st), .req_ack(req_ack),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wr(req_wr),
    .req_mem(req_mem), .req_be(req_be), .ready(ready), .ad_in(ad_in),
    .addr_q(addr_q), .wdata_q(wdata_q), .wr_q(wr_q), .mem_q(mem_q),
    .be_q(be_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  mbs_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st), .addr_q(addr_q), .wdata_q(wdata_q),
    .wr_q(wr_q), .mem_q(mem_q), .be_q(be_q), .ad_out(ad_out), .ad_oe(ad_oe),
    .ctl_oe(ctl_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n)
  );

  p_hold_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ctl_oe));
  p_ack_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (ale && !hlda));
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_wr, req_mem;
  logic [1:0]    req_be;
  logic          req_ack;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          ready, hold, hlda;
  logic [AW-1:0] ad_out;
  logic          ad_oe;
  logic [DW-1:0] ad_in;
  logic          ctl_oe, ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq #(.AW(AW), .DW(DW)) u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wr(req_wr), .req_mem(req_mem), .req_be(req_be),
    .req_ack(req_ack), .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready),
    .hold(hold), .hlda(hlda), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ctl_oe(ctl_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n)
  );

  // phase codes: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4, 6 hold
  function automatic logic [9:0] exp_ctl(int ph, logic wr, logic mem, logic [1:0] be);
    logic inc, dat, stb;
    inc = (ph >= 1 && ph <= 5);
    dat = (ph >= 2 && ph <= 5);
    stb = (ph >= 2 && ph <= 4);
    return {ph == 1, !(stb && !wr), !(stb && wr), !dat, inc ? wr : 1'b1,
            inc ? mem : 1'b1, inc ? ~be[1] : 1'b1, (ph == 1) || (dat && wr),
            ph != 6, ph == 6};
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic [1:0] be);
    return {a[AW-1:1], ~be[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_ctl(input int ph, input string tag);
    logic [9:0] a, e;
    a = {ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n, ad_oe, ctl_oe, hlda};
    e = exp_ctl(ph, req_wr, req_mem, req_be);
    check(a === e, tag, {22'd0, a}, {22'd0, e});
  endtask

  // current request fields, held in the bench during the cycle
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata, f_rdata;
  logic          f_wr, f_mem;
  logic [1:0]    f_be;

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic w, input logic m, input logic [1:0] b);
    f_addr = a; f_wdata = d; f_wr = w; f_mem = m; f_be = b;
    req_addr = a; req_wdata = d; req_wr = w; req_mem = m; req_be = b;
    req_valid = 1'b1;
    #1;
    check(req_ack === 1'b1, "R2 request accepted at boundary", {31'd0, req_ack}, 32'd1);
  endtask

  // runs T1 .. T4; returns in the T4 slot after its checks
  task automatic phases(input int waits, input logic [DW-1:0] rdv, input bit hold_mid);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check_ctl(1, "R3 R7 R8 T1 controls");
    check(ad_out === exp_addr(f_addr, f_be), "R3 R8 T1 address",
          {12'd0, ad_out}, {12'd0, exp_addr(f_addr, f_be)});
    @(negedge clk);
    if (hold_mid) hold = 1'b1;
    #1;
    check_ctl(2, f_wr ? "R5 R6 T2 write controls" : "R4 R6 T2 read controls");
    if (f_wr) check(ad_out === {4'd0, f_wdata}, "R5 T2 write data",
                    {12'd0, ad_out}, {16'd0, f_wdata});
    @(negedge clk);
    ready = (waits == 0);
    ad_in = rdv;
    f_rdata = rdv;
    #1;
    check_ctl(3, "R4 R5 R6 T3 controls");
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (i == waits - 1) ready = 1'b1;
      #1;
      check_ctl(4, "R9 R10 wait state controls");
      if (f_wr) check(ad_out === {4'd0, f_wdata}, "R10 wait state data",
                      {12'd0, ad_out}, {16'd0, f_wdata});
    end
    @(negedge clk);
    ad_in = ~rdv;
    #1;
    check_ctl(5, "R2 R9 T4 controls");
    if (f_wr) check(ad_out === {4'd0, f_wdata}, "R5 T4 write data",
                    {12'd0, ad_out}, {16'd0, f_wdata});
    else check(rd_valid === 1'b1 && rd_data === f_rdata, "R4 read data in T4",
               {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, f_rdata});
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check_ctl(0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
    req_wr = 1'b0; req_mem = 1'b1; req_be = 2'b11; ready = 1'b1; hold = 1'b0;
    ad_in = '0;
    repeat (3) @(negedge clk);
    #1;
    req_wr = 1'b0; req_mem = 1'b1; req_be = 2'b11;
    check_ctl(0, "R1 outputs during reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_ctl(0, "R1 idle after reset");

    // directed: word read from odd address, bit 0 overridden (R8), no waits
    @(negedge clk);
    issue(20'h12345, 16'h0, 1'b0, 1'b1, 2'b11);
    phases(0, 16'hBEEF, 0);
    idle_check("R2 idle after read");

    // directed: I/O write upper byte, two waits (R7 R8 R9)
    issue(20'h00400, 16'hA55A, 1'b1, 1'b0, 2'b10);
    phases(2, 16'h0, 0);
    // back-to-back: lower-byte memory read chained at T4 (R2)
    issue(20'h00402, 16'h0, 1'b0, 1'b1, 2'b01);
    phases(1, 16'h1234, 0);
    idle_check("R2 idle after chained read");

    // directed: hold in idle competes with a request (R11 R12)
    hold = 1'b1;
    req_valid = 1'b1;
    #1;
    check(req_ack === 1'b0, "R11 hold beats request in idle", {31'd0, req_ack}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check_ctl(6, "R11 R12 hold granted from idle");
    check(ad_oe === 1'b0 && ctl_oe === 1'b0, "R12 outputs released",
          {30'd0, ad_oe, ctl_oe}, 32'd0);
    hold = 1'b0;
    @(negedge clk);
    #1;
    req_wr = 1'b0; req_mem = 1'b1; req_be = 2'b11;
    check_ctl(0, "R12 hold released to idle");

    // directed: hold raised mid-cycle only honoured after T4 (R11)
    issue(20'h0F0F0, 16'h7777, 1'b1, 1'b1, 2'b11);
    phases(1, 16'h0, 1);
    req_valid = 1'b1;
    #1;
    check(req_ack === 1'b0, "R11 hold beats request at T4", {31'd0, req_ack}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check_ctl(6, "R11 hold granted after T4");
    hold = 1'b0;
    @(negedge clk);
    #1;
    check_ctl(0, "R12 idle after hold drops");

    // random: mix of reads/writes, lanes, waits and chaining
    begin
      bit chain;
      issue($urandom, $urandom, $urandom % 2, $urandom % 2, $urandom % 4);
      for (int k = 0; k < 60; k++) begin
        phases($urandom % 4, $urandom, 0);
        if (k == 59) begin
          idle_check("R2 idle at end of random run");
        end else begin
          chain = $urandom % 2;
          if (!chain) idle_check("R2 idle between random cycles");
          issue($urandom, $urandom, $urandom % 2, $urandom % 2, $urandom % 4);
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule